// File: doc/BRIEF.md
# IrDA Pulse Encoder and Decoder

This block sits between the serial bit stream of a UART and an infrared transceiver. On the transmit side it turns every zero bit into a short light pulse and leaves one bits dark. The pulse length is a programmable number of half periods of a pulse-timing clock. That clock is given as a single-domain enable that fires twice per pulse-clock period. One of two such enables is chosen: an oversampled bit clock or the raw baud source clock.

On the receive side the raw infrared pin is first mapped to a "light" level through a polarity select, then synchronised. When a pulse is accepted, the recovered line goes low, and it returns to mark one full bit period after the pulse's leading edge. An optional filter accepts a pulse only after it has stayed lit for a programmable minimum number of half periods, so that glitches are rejected.

When the infrared function is disabled, both directions pass the UART signals through unchanged. The encoder and decoder state is then held cleared.

Top module: `ir_pulse_codec`

## Requirements
- R1: While and right after reset with `ir_en`=1, `ir_tx` is 0 (dark) and `rx_bit` is 1 (mark).
- R2: With `ir_en`=1, a `tx_start` strobe with `tx_bit`=0 makes `ir_tx` go high at that clock edge. `ir_tx` stays high through exactly `tx_width`+1 selected half ticks, counting the cycle of the last tick, and is low in the cycle after that tick.
- R3: A `tx_start` strobe with `tx_bit`=1 produces no pulse: `ir_tx` stays 0.
- R4: `tick_sel_os`=1 selects `tick_os` as the half tick and `tick_sel_os`=0 selects `tick_raw`. The other tick has no effect on pulse length or on filter counting.
- R5: With the oversampled tick firing 32 times per bit, `tx_width`=5 gives a pulse of 3/16 of a bit. For a 64-cycle bit with a tick every second cycle, that is 12 cycles.
- R6: A zero-bit strobe in the same cycle as the final tick of a running pulse restarts the count. The pulse then continues without a gap for another `tx_width`+1 ticks.
- R7: The light level is `rx_pin` XOR `rx_low_active`. A value of 0 means a light pulse is high on the pin, and 1 means it is low.
- R8: With the filter off, a light level that starts in cycle 0 makes `rx_bit` low from the third clock edge after it. `rx_bit` stays low for exactly `bit_len` cycles (1 ≤ `bit_len`), i.e. until `bit_len`+2 edges after the leading edge.
- R9: With the filter on, a pulse is accepted only if it stays lit for at least `flt_len`+4 selected half ticks. Acceptance drives `rx_bit` low one edge after the threshold tick, and the line returns to mark at the same edge as in R8. A rejected pulse leaves `rx_bit` at 1.
- R10: With `ir_en`=0, `ir_tx` equals `tx_bit` and `rx_bit` equals `rx_pin` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_en | input | 1 | 1 = infrared coding active, 0 = pass-through |
| tick_os | input | 1 | Half-period enable derived from the oversampled bit clock |
| tick_raw | input | 1 | Half-period enable derived from the baud source clock |
| tick_sel_os | input | 1 | 1 selects `tick_os`, 0 selects `tick_raw` |
| tx_bit | input | 1 | UART transmit bit value |
| tx_start | input | 1 | One-cycle strobe at the start of each transmit bit |
| tx_width | input | PW_BITS (6) | Pulse length minus one, in half ticks |
| ir_tx | output | 1 | Infrared transmit drive, high = light |
| rx_pin | input | 1 | Raw infrared receive pin |
| rx_low_active | input | 1 | Receive polarity: 1 = light shows as low |
| flt_en | input | 1 | Enables the minimum-length filter |
| flt_len | input | FL_BITS (6) | Minimum lit length minus four, in half ticks |
| bit_len | input | BIT_BITS (16) | Bit period in clock cycles |
| rx_bit | output | 1 | Recovered receive bit stream |

## Verification
Two events can coincide on the transmit side: a new zero-bit strobe and the final selected half tick of the pulse already running. The bench provokes this with hand-placed ticks that put both in one cycle. It then judges the result by counting contiguous high samples of `ir_tx` against twice the programmed length; any gap or early end shows up as a short count. Receive pulses are placed exactly at and one below the filter threshold, and the first and last low cycles of `rx_bit` are compared with offsets computed from the leading edge.

// File: rtl/ir_codec_pkg.sv
package ir_codec_pkg;

    localparam int DEF_PW_BITS     = 6;
    localparam int DEF_FL_BITS     = 6;
    localparam int DEF_BIT_BITS    = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        SRC_RAW = 1'b0,
        SRC_OS  = 1'b1
    } tick_src_e;

endpackage

// File: rtl/ir_tick_mux.sv
module ir_tick_mux
    import ir_codec_pkg::*;
(
    input  logic sel_os,
    input  logic tick_os,
    input  logic tick_raw,
    output logic tick
);

    tick_src_e src;

    assign src  = tick_src_e'(sel_os);
    assign tick = (src == SRC_OS) ? tick_os : tick_raw;

endmodule

// File: rtl/ir_pulse_enc.sv
module ir_pulse_enc #(
    parameter int PW_BITS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               start,
    input  logic               bit_in,
    input  logic [PW_BITS-1:0] width,
    output logic               pulse
);

    localparam int CW = PW_BITS + 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } enc_s;

    enc_s st_q, st_d;
    logic fire;

    assign fire = start && !bit_in;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (fire) begin
            st_d.active = 1'b1;
            st_d.cnt    = {1'b0, width} + CW'(1);
        end else if (st_q.active && tick) begin
            if (st_q.cnt <= CW'(1)) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.active;

    // A zero bit always lights the output at the next edge
    assert_zero_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start && !bit_in) |=> pulse);

    // The output only goes dark on a selected half tick (or when disabled)
    assert_end_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> ($past(tick) || !$past(en)));

    // A dark output stays dark unless a zero bit is strobed
    assert_one_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !(en && start && !bit_in)) |=> !pulse);

endmodule

// File: rtl/ir_pulse_dec.sv
module ir_pulse_dec #(
    parameter int FL_BITS     = 6,
    parameter int BIT_BITS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                tick,
    input  logic                pin,
    input  logic                low_active,
    input  logic                flt_en,
    input  logic [FL_BITS-1:0]  flt_len,
    input  logic [BIT_BITS-1:0] bit_len,
    output logic                held
);

    localparam int RW = FL_BITS + 1;
    localparam logic [RW-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [RW-1:0]          run;
        logic [BIT_BITS-1:0]    age;
        logic                   held;
    } dec_s;

    dec_s st_q, st_d;
    logic          lit;
    logic          rise;
    logic          accept;
    logic [RW-1:0] need;

    assign lit  = st_q.sync[SYNC_STAGES-1];
    assign rise = lit && !st_q.prev;
    assign need = {1'b0, flt_len} + RW'(4);

    always_comb begin
        st_d      = st_q;
        st_d.sync = (st_q.sync << 1) | SYNC_STAGES'(pin ^ low_active);
        st_d.prev = lit;

        if (!lit) begin
            st_d.run = '0;
        end else if (rise) begin
            st_d.run = RW'(tick);
        end else if (tick && (st_q.run != RUN_MAX)) begin
            st_d.run = st_q.run + RW'(1);
        end

        if (rise) begin
            st_d.age = BIT_BITS'(1);
        end else if ((st_q.age != '0) && (st_q.age < bit_len)) begin
            st_d.age = st_q.age + BIT_BITS'(1);
        end else begin
            st_d.age = '0;
        end

        accept    = lit && (!flt_en || (st_d.run >= need));
        st_d.held = (st_d.age != '0) && ((st_q.held && !rise) || accept);

        if (!en) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.held;

    // A stretch can only begin while the synchronised input is lit
    assert_accept_needs_light_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(lit));

    // The low stretch never outlives one bit period from the leading edge
    assert_window_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && (bit_len != '0)) |-> ((st_q.age != '0) && (st_q.age <= bit_len)));

endmodule

// File: rtl/ir_pulse_codec.sv
module ir_pulse_codec
    import ir_codec_pkg::*;
#(
    parameter int PW_BITS     = DEF_PW_BITS,
    parameter int FL_BITS     = DEF_FL_BITS,
    parameter int BIT_BITS    = DEF_BIT_BITS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ir_en,
    input  logic                tick_os,
    input  logic                tick_raw,
    input  logic                tick_sel_os,
    input  logic                tx_bit,
    input  logic                tx_start,
    input  logic [PW_BITS-1:0]  tx_width,
    output logic                ir_tx,
    input  logic                rx_pin,
    input  logic                rx_low_active,
    input  logic                flt_en,
    input  logic [FL_BITS-1:0]  flt_len,
    input  logic [BIT_BITS-1:0] bit_len,
    output logic                rx_bit
);

    logic half_tick;
    logic enc_pulse;
    logic dec_held;

    ir_tick_mux u_mux (
        .sel_os   (tick_sel_os),
        .tick_os  (tick_os),
        .tick_raw (tick_raw),
        .tick     (half_tick)
    );

    ir_pulse_enc #(.PW_BITS(PW_BITS)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ir_en),
        .tick   (half_tick),
        .start  (tx_start),
        .bit_in (tx_bit),
        .width  (tx_width),
        .pulse  (enc_pulse)
    );

    ir_pulse_dec #(
        .FL_BITS     (FL_BITS),
        .BIT_BITS    (BIT_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ir_en),
        .tick       (half_tick),
        .pin        (rx_pin),
        .low_active (rx_low_active),
        .flt_en     (flt_en),
        .flt_len    (flt_len),
        .bit_len    (bit_len),
        .held       (dec_held)
    );

    assign ir_tx  = ir_en ? enc_pulse : tx_bit;
    assign rx_bit = ir_en ? !dec_held : rx_pin;

endmodule

// File: tb/sim_ir_pulse_codec.sv
`timescale 1ns/1ps
module sim_ir_pulse_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_en = 1'b1;
    logic        tick_os = 1'b0, tick_raw = 1'b0, tick_sel_os = 1'b0;
    logic        tx_bit = 1'b1, tx_start = 1'b0;
    logic [5:0]  tx_width = 6'd0;
    logic        ir_tx;
    logic        rx_pin = 1'b0, rx_low_active = 1'b0, flt_en = 1'b0;
    logic [5:0]  flt_len = 6'd0;
    logic [15:0] bit_len = 16'd40;
    logic        rx_bit;

    logic s_tx, s_rx;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ir_pulse_codec u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t_os, input logic t_raw, input logic stb);
        tick_os = t_os; tick_raw = t_raw; tx_start = stb;
        @(negedge clk);
        s_tx = ir_tx; s_rx = rx_bit;
        @(posedge clk); #1;
    endtask

    // R2 R3 R4: one transmit bit with random ticks on both sources
    task automatic tx_bit_case(input logic b, input int pl, input logic sel, input int dens);
        int got = 0, hi_ticks = 0, hi_cyc = 0;
        tx_bit = b; tx_width = 6'(pl); tick_sel_os = sel;
        cyc(1'b0, 1'b0, 1'b1);
        while (got < pl + 1) begin
            logic o = ($urandom % dens) == 0;
            logic r = ($urandom % dens) == 0;
            logic st = sel ? o : r;
            cyc(o, r, 1'b0);
            if (st) got++;
            if (st && s_tx) hi_ticks++;
            if (s_tx) hi_cyc++;
        end
        cyc(1'b0, 1'b0, 1'b0);
        if (b) begin
            chk("R3 one bit high cycles", hi_cyc, 0);
        end else begin
            chk("R2 R4 ticks while lit", hi_ticks, pl + 1);
            chk("R2 dark after last tick", int'(s_tx), 0);
        end
    endtask

    // R7 R8 R9: one receive pulse, continuous ticks
    task automatic rx_case(input int n, input logic f, input int fl, input logic pol, input int bl);
        int first = -1, last = -1, lows = 0, need;
        need = fl + 4;
        flt_en = f; flt_len = 6'(fl); rx_low_active = pol; bit_len = 16'(bl);
        rx_pin = pol;
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0);
        chk("R7 idle mark", int'(s_rx), 1);
        for (int idx = 0; idx < bl + 12; idx++) begin
            rx_pin = (idx < n) ? !pol : pol;
            cyc(1'b1, 1'b1, 1'b0);
            if (!s_rx) begin
                if (first < 0) first = idx;
                last = idx;
                lows++;
            end
        end
        if (!f) begin
            chk("R8 R7 first low", first, 3);
            chk("R8 R7 last low", last, bl + 2);
            chk("R8 low count", lows, bl);
        end else if (n >= need) begin
            chk("R9 first low", first, need + 2);
            chk("R9 last low", last, bl + 2);
        end else begin
            chk("R9 rejected low count", lows, 0);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset ir_tx", int'(ir_tx), 0);
        chk("R1 reset rx_bit", int'(rx_bit), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R1 after reset ir_tx", int'(s_tx), 0);
        chk("R1 after reset rx_bit", int'(s_rx), 1);

        // Directed transmit corners
        tx_bit_case(1'b0, 0, 1'b0, 2);
        tx_bit_case(1'b0, 63, 1'b1, 2);
        tx_bit_case(1'b1, 7, 1'b0, 3);

        // R5: 3/16 bit pulse, 64-cycle bit, oversampled tick every 2nd cycle
        begin
            int hi = 0;
            tx_bit = 1'b0; tx_width = 6'd5; tick_sel_os = 1'b1;
            cyc(1'b0, 1'b0, 1'b1);
            for (int c = 1; c < 64; c++) begin
                cyc((c % 2) == 0, 1'b1, 1'b0);
                if (s_tx) hi++;
            end
            chk("R5 3/16 bit high cycles", hi, 12);
        end

        // R6: new zero-bit strobe on the final tick of the running pulse
        begin
            int pl = 4, hi = 0;
            tx_bit = 1'b0; tx_width = 6'(pl); tick_sel_os = 1'b0;
            cyc(1'b0, 1'b0, 1'b1);
            for (int c = 0; c < pl; c++) begin cyc(1'b0, 1'b1, 1'b0); if (s_tx) hi++; end
            cyc(1'b0, 1'b1, 1'b1); if (s_tx) hi++;
            for (int c = 0; c <= pl; c++) begin cyc(1'b0, 1'b1, 1'b0); if (s_tx) hi++; end
            chk("R6 contiguous high samples", hi, 2 * (pl + 1));
            cyc(1'b0, 1'b0, 1'b0);
            chk("R6 dark after restarted pulse", int'(s_tx), 0);
        end

        // R4: non-selected tick alone never ends a pulse
        begin
            tx_bit = 1'b0; tx_width = 6'd0; tick_sel_os = 1'b1;
            cyc(1'b0, 1'b0, 1'b1);
            for (int c = 0; c < 10; c++) cyc(1'b0, 1'b1, 1'b0);
            chk("R4 raw tick ignored", int'(s_tx), 1);
            cyc(1'b1, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0);
            chk("R4 os tick ends pulse", int'(s_tx), 0);
        end

        // Random transmit bits
        for (int k = 0; k < 60; k++) begin
            tx_bit_case(1'($urandom % 2), int'($urandom % 64), 1'($urandom % 2),
                        int'(1 + $urandom % 4));
        end

        // Directed receive corners: threshold and one below, both polarities
        rx_case(1, 1'b0, 0, 1'b0, 40);
        rx_case(5, 1'b0, 3, 1'b1, 30);
        rx_case(7, 1'b1, 3, 1'b0, 40);
        rx_case(6, 1'b1, 3, 1'b0, 40);
        rx_case(20, 1'b1, 16, 1'b1, 50);
        rx_case(19, 1'b1, 16, 1'b1, 50);

        // Random receive pulses
        for (int k = 0; k < 40; k++) begin
            rx_case(int'(1 + $urandom % 20), 1'($urandom % 2), int'($urandom % 13),
                    1'($urandom % 2), int'(30 + $urandom % 31));
        end

        // R10: pass-through when disabled
        ir_en = 1'b0;
        for (int k = 0; k < 24; k++) begin
            tx_bit = 1'($urandom % 2);
            rx_pin = 1'($urandom % 2);
            cyc(1'b1, 1'b1, 1'($urandom % 2));
            chk("R10 ir_tx follows tx_bit", int'(s_tx), int'(tx_bit));
            chk("R10 rx_bit follows rx_pin", int'(s_rx), int'(rx_pin));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule